// File: doc/BRIEF.md
# Fixed-Point ALU Datapath

This block is the arithmetic and logic unit of a small fixed-point signal-processing core. On each issued operation it takes an x operand and a y operand of 16 bits in two's complement, computes one of fourteen functions (the add and subtract forms with and without carry, bitwise logic, pass, invert, absolute value, increment and decrement), and writes the result into one of two output registers. One is the result register. It can be selected back as the x operand. The other is the feedback register. It can be selected back as the y operand. Four status flags (zero, negative, overflow, carry) are registered alongside the result.

The x operand is either an external value or the result register. The y operand is an external value, the feedback register, zero, or a small-encoded immediate. The immediate is a power of two, the complement of one, or one of the two extreme values. A condition input from the sequencer turns an issued operation into a no-operation. Two mode inputs shape the writeback. Saturation clamps overflowing results. Overflow-latch mode makes the overflow flag sticky until an explicit clear.

Top module: `fxp_alu`

## Requirements
- R1: Arithmetic opcodes compute, on 16-bit values: 0 x+y, 1 x+y+C, 2 x-y, 3 x-y+C-1, 4 y-x, 5 y-x+C-1, 12 y+1, 13 y-1, where C is the current carry flag. For subtracts the carry flag is the not-borrow of the full unsigned difference (1 when no borrow occurred). For increment, carry is set when y was 0xFFFF. For decrement, carry is set when y was nonzero.
- R2: Logic opcodes compute 6 x AND y, 7 x OR y, 8 x XOR y, 9 pass y, 10 NOT x. Opcode 11 returns the absolute value of x.
- R3: Destination input 0 writes the result register and leaves the feedback register unchanged. Destination input 1 does the opposite. The x select picks the external x (0) or the result register (1). The y select picks external y (0), the feedback register (1), zero (2) or the immediate (3). A register written in one cycle is usable as an operand in the next cycle.
- R4: Immediate encoding: with the special flag 0, the value is 1 shifted left by the 4-bit index, bitwise inverted when the invert flag is 1. With the special flag 1, the value is 0x7FFF when invert is 0 and 0x8000 when invert is 1.
- R5: An operation executes only when issue and condition are both 1 and the opcode is 0 to 13. Otherwise, including opcodes 14 and 15, neither register nor any flag except a requested overflow clear changes.
- R6: On an executed operation the zero flag is set exactly when the written value is 0. The negative flag is bit 15 of the written value, except for absolute value, where it is bit 15 of the input x.
- R7: The overflow flag reports two's-complement overflow of the exact result. Logic, pass and NOT clear overflow and carry. Absolute value clears carry and overflows only for 0x8000, which it returns unchanged when saturation is off.
- R8: With saturation on, an overflowing result is written as 0x7FFF when the exact result is positive and 0x8000 when negative. The overflow flag is still set.
- R9: With overflow-latch on, an executed operation sets the overflow flag to its own overflow OR the previous flag. The overflow-clear input removes the previous flag's contribution. It clears the flag in a cycle with no executed operation.
- R10: Active-low reset clears both registers and all four flags. Results and flags appear on the clock edge that samples the issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An operation is presented this cycle |
| cond_ok_i | input | 1 | Condition result; 1 for unconditional operations |
| op_i | input | 4 | Opcode |
| x_sel_i | input | 1 | x source: 0 external, 1 result register |
| y_sel_i | input | 2 | y source: 0 external, 1 feedback register, 2 zero, 3 immediate |
| x_ext_i | input | 16 | External x operand |
| y_ext_i | input | 16 | External y operand |
| imm_idx_i | input | 4 | Immediate bit index |
| imm_inv_i | input | 1 | Immediate invert flag |
| imm_spec_i | input | 1 | Immediate special-value flag |
| dest_fb_i | input | 1 | Destination: 0 result register, 1 feedback register |
| sat_en_i | input | 1 | Saturation mode |
| ov_latch_i | input | 1 | Overflow-latch mode |
| ov_clr_i | input | 1 | Overflow flag clear |
| res_o | output | 16 | Result register |
| fb_o | output | 16 | Feedback register |
| zf_o | output | 1 | Zero flag |
| nf_o | output | 1 | Negative flag |
| vf_o | output | 1 | Overflow flag |
| cf_o | output | 1 | Carry flag |

## Verification
A corrupted result or feedback register shows up on its output one edge after the operation that wrote it. A wrong register is also fed forward by the next operation that selects it, so an error spreads into later values and flags within a cycle. A wrong carry flag only becomes visible in data when a later carry-consuming add or subtract runs. For that reason the sweep runs every opcode back to back, so each carry state feeds the following operation. A stale overflow flag under latch mode shows only through the flag port, and it can persist for many cycles until a clear.

// File: rtl/fxp_alu_pkg.sv
package fxp_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_RSB  = 4'd4,
    OP_RSBB = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_PASS = 4'd9,
    OP_NOT  = 4'd10,
    OP_ABS  = 4'd11,
    OP_INC  = 4'd12,
    OP_DEC  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    YS_EXT  = 2'd0,
    YS_FB   = 2'd1,
    YS_ZERO = 2'd2,
    YS_IMM  = 2'd3
  } ysel_e;

  typedef struct packed {
    logic zf;
    logic nf;
    logic vf;
    logic cf;
  } alu_flags_t;

endpackage

// File: rtl/fxp_imm_expand.sv
module fxp_imm_expand #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [IW-1:0] idx_i,
  input  logic          inv_i,
  input  logic          spec_i,
  output logic [W-1:0]  val_o
);

  logic [W-1:0] onehot;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign onehot[b] = (idx_i == IW'(b));
  end

  always_comb begin
    if (spec_i) begin
      val_o = {inv_i, {(W-1){~inv_i}}};
    end else begin
      val_o = inv_i ? ~onehot : onehot;
    end
  end

endmodule

// File: rtl/fxp_alu_core.sv
module fxp_alu_core
  import fxp_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sat_en_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         cout_o,
  output logic         sign_o,
  output logic         valid_o
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] a, b, lres, raw;
  logic         c0, arith, is_abs;
  logic [W:0]   sum;

  always_comb begin
    a      = x_i;
    b      = '0;
    c0     = 1'b0;
    arith  = 1'b1;
    is_abs = 1'b0;
    lres   = '0;
    unique case (alu_op_e'(op_i))
      OP_ADD:  begin b = y_i; end
      OP_ADC:  begin b = y_i; c0 = cin_i; end
      OP_SUB:  begin b = ~y_i; c0 = 1'b1; end
      OP_SBB:  begin b = ~y_i; c0 = cin_i; end
      OP_RSB:  begin a = y_i; b = ~x_i; c0 = 1'b1; end
      OP_RSBB: begin a = y_i; b = ~x_i; c0 = cin_i; end
      OP_INC:  begin a = y_i; c0 = 1'b1; end
      OP_DEC:  begin a = y_i; b = '1; end
      OP_ABS: begin
        is_abs = 1'b1;
        if (x_i[W-1]) begin
          a  = '0;
          b  = ~x_i;
          c0 = 1'b1;
        end
      end
      OP_AND:  begin arith = 1'b0; lres = x_i & y_i; end
      OP_OR:   begin arith = 1'b0; lres = x_i | y_i; end
      OP_XOR:  begin arith = 1'b0; lres = x_i ^ y_i; end
      OP_PASS: begin arith = 1'b0; lres = y_i; end
      OP_NOT:  begin arith = 1'b0; lres = ~x_i; end
      default: begin arith = 1'b0; end
    endcase
  end

  assign sum     = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c0};
  assign ovf_o   = arith & (a[W-1] == b[W-1]) & (sum[W-1] != a[W-1]);
  assign raw     = arith ? sum[W-1:0] : lres;
  assign res_o   = (ovf_o & sat_en_i) ? (a[W-1] ? MINV : MAXV) : raw;
  assign cout_o  = arith & ~is_abs & sum[W];
  assign sign_o  = is_abs ? x_i[W-1] : res_o[W-1];
  assign valid_o = (op_i != OP_RSV0) && (op_i != OP_RSV1);

endmodule

// File: rtl/fxp_alu_regs.sv
module fxp_alu_regs
  import fxp_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_i,
  input  logic         dest_fb_i,
  input  logic [W-1:0] res_i,
  input  logic         ovf_i,
  input  logic         cout_i,
  input  logic         sign_i,
  input  logic         ov_latch_i,
  input  logic         ov_clr_i,
  output logic [W-1:0] res_q_o,
  output logic [W-1:0] fb_q_o,
  output alu_flags_t   flags_o
);

  logic [W-1:0] res_q, res_d, fb_q, fb_d;
  alu_flags_t   fl_q, fl_d;
  logic         keep_ov, reg_en;

  assign keep_ov = ov_latch_i & fl_q.vf & ~ov_clr_i;
  assign reg_en  = exec_i | ov_clr_i;

  always_comb begin
    res_d = res_q;
    fb_d  = fb_q;
    fl_d  = fl_q;
    if (exec_i) begin
      if (dest_fb_i) fb_d = res_i;
      else           res_d = res_i;
      fl_d.zf = (res_i == '0);
      fl_d.nf = sign_i;
      fl_d.cf = cout_i;
      fl_d.vf = ovf_i | keep_ov;
    end else if (ov_clr_i) begin
      fl_d.vf = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      fb_q  <= '0;
      fl_q  <= '0;
    end else if (reg_en) begin
      res_q <= res_d;
      fb_q  <= fb_d;
      fl_q  <= fl_d;
    end
  end

  assign res_q_o = res_q;
  assign fb_q_o  = fb_q;
  assign flags_o = fl_q;

endmodule

// File: rtl/fxp_alu.sv
module fxp_alu
  import fxp_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          cond_ok_i,
  input  logic [3:0]    op_i,
  input  logic          x_sel_i,
  input  logic [1:0]    y_sel_i,
  input  logic [W-1:0]  x_ext_i,
  input  logic [W-1:0]  y_ext_i,
  input  logic [IW-1:0] imm_idx_i,
  input  logic          imm_inv_i,
  input  logic          imm_spec_i,
  input  logic          dest_fb_i,
  input  logic          sat_en_i,
  input  logic          ov_latch_i,
  input  logic          ov_clr_i,
  output logic [W-1:0]  res_o,
  output logic [W-1:0]  fb_o,
  output logic          zf_o,
  output logic          nf_o,
  output logic          vf_o,
  output logic          cf_o
);

  logic [W-1:0] imm_val, x_op, y_op, core_res;
  logic         core_ovf, core_cout, core_sign, core_valid, exec;
  alu_flags_t   flags;

  fxp_imm_expand #(.W(W), .IW(IW)) u_imm (
    .idx_i  (imm_idx_i),
    .inv_i  (imm_inv_i),
    .spec_i (imm_spec_i),
    .val_o  (imm_val)
  );

  assign x_op = x_sel_i ? res_o : x_ext_i;

  always_comb begin
    unique case (ysel_e'(y_sel_i))
      YS_EXT:  y_op = y_ext_i;
      YS_FB:   y_op = fb_o;
      YS_ZERO: y_op = '0;
      default: y_op = imm_val;
    endcase
  end

  fxp_alu_core #(.W(W)) u_core (
    .op_i     (op_i),
    .x_i      (x_op),
    .y_i      (y_op),
    .cin_i    (cf_o),
    .sat_en_i (sat_en_i),
    .res_o    (core_res),
    .ovf_o    (core_ovf),
    .cout_o   (core_cout),
    .sign_o   (core_sign),
    .valid_o  (core_valid)
  );

  assign exec = issue_i & cond_ok_i & core_valid;

  fxp_alu_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_i     (exec),
    .dest_fb_i  (dest_fb_i),
    .res_i      (core_res),
    .ovf_i      (core_ovf),
    .cout_i     (core_cout),
    .sign_i     (core_sign),
    .ov_latch_i (ov_latch_i),
    .ov_clr_i   (ov_clr_i),
    .res_q_o    (res_o),
    .fb_q_o     (fb_o),
    .flags_o    (flags)
  );

  assign zf_o = flags.zf;
  assign nf_o = flags.nf;
  assign vf_o = flags.vf;
  assign cf_o = flags.cf;

endmodule

// File: rtl/fxp_alu_checker.sv
module fxp_alu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue_i,
  input logic         cond_ok_i,
  input logic [3:0]   op_i,
  input logic         dest_fb_i,
  input logic         sat_en_i,
  input logic         ov_latch_i,
  input logic         ov_clr_i,
  input logic [W-1:0] res_o,
  input logic [W-1:0] fb_o,
  input logic         zf_o,
  input logic         nf_o,
  input logic         vf_o,
  input logic         cf_o
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic fire, is_logic;
  assign fire     = issue_i & cond_ok_i & (op_i < 4'd14);
  assign is_logic = (op_i >= 4'd6) && (op_i <= 4'd10);

  p_nop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !ov_clr_i) |=> ($stable(res_o) && $stable(fb_o) &&
                              $stable({zf_o, nf_o, vf_o, cf_o})));

  p_fb_dest_keeps_res_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dest_fb_i) |=> $stable(res_o));

  p_res_dest_keeps_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dest_fb_i) |=> $stable(fb_o));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dest_fb_i) |=> (zf_o == (res_o == '0)));

  p_logic_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_logic && !ov_latch_i) |=> (!cf_o && !vf_o));

  p_sat_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sat_en_i && !dest_fb_i && !ov_latch_i) |=>
      (!vf_o || res_o == MAXV || res_o == MINV));

  p_ov_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_o && ov_latch_i && !ov_clr_i) |=> vf_o);

  p_ov_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_clr_i && !fire) |=> !vf_o);

endmodule

bind fxp_alu fxp_alu_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_i    (issue_i),
  .cond_ok_i  (cond_ok_i),
  .op_i       (op_i),
  .dest_fb_i  (dest_fb_i),
  .sat_en_i   (sat_en_i),
  .ov_latch_i (ov_latch_i),
  .ov_clr_i   (ov_clr_i),
  .res_o      (res_o),
  .fb_o       (fb_o),
  .zf_o       (zf_o),
  .nf_o       (nf_o),
  .vf_o       (vf_o),
  .cf_o       (cf_o)
);

// File: tb/fxp_alu_bench.sv
`timescale 1ns/1ps
module fxp_alu_bench;

  logic        clk, rst_n;
  logic        issue, cond, xs, clr, dst, sat, lat, iinv, ispec;
  logic [3:0]  op, iidx;
  logic [1:0]  ys;
  logic [15:0] xe, ye;
  logic [15:0] res, fb;
  logic        zf, nf, vf, cf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_res, m_fb;
  logic        m_zf, m_nf, m_vf, m_cf;

  fxp_alu u_fxp_alu (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .cond_ok_i(cond), .op_i(op),
    .x_sel_i(xs), .y_sel_i(ys), .x_ext_i(xe), .y_ext_i(ye),
    .imm_idx_i(iidx), .imm_inv_i(iinv), .imm_spec_i(ispec),
    .dest_fb_i(dst), .sat_en_i(sat), .ov_latch_i(lat), .ov_clr_i(clr),
    .res_o(res), .fb_o(fb), .zf_o(zf), .nf_o(nf), .vf_o(vf), .cf_o(cf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string rd, input string rz, input string rv);
    chk(res == m_res, rd, "result reg", {16'h0, res}, {16'h0, m_res});
    chk(fb == m_fb,   rd, "feedback reg", {16'h0, fb}, {16'h0, m_fb});
    chk({zf, nf} == {m_zf, m_nf}, rz, "zf/nf", {30'h0, zf, nf}, {30'h0, m_zf, m_nf});
    chk({vf, cf} == {m_vf, m_cf}, rv, "vf/cf", {30'h0, vf, cf}, {30'h0, m_vf, m_cf});
  endtask

  // One operation: drive at a falling edge, model it, check at the next falling edge.
  task automatic run(input logic [3:0] o, input logic xsel, input logic [1:0] ysel,
                     input logic [15:0] xv, input logic [15:0] yv,
                     input logic [3:0] ix, input logic iv, input logic sp,
                     input logic d, input logic s, input logic l, input logic c,
                     input logic is, input logic cd,
                     input string rd, input string rz, input string rv);
    logic [15:0] x, y, imm, r;
    int sx, sy, ux, uy, e;
    bit ov, cy, ar, ex;
    op = o; xs = xsel; ys = ysel; xe = xv; ye = yv; iidx = ix; iinv = iv;
    ispec = sp; dst = d; sat = s; lat = l; clr = c; issue = is; cond = cd;
    if (sp) imm = iv ? 16'h8000 : 16'h7FFF;
    else    imm = iv ? ~(16'h1 << ix) : (16'h1 << ix);
    x = xsel ? m_res : xv;
    case (ysel)
      2'd0: y = yv;
      2'd1: y = m_fb;
      2'd2: y = 16'h0;
      default: y = imm;
    endcase
    sx = int'($signed(x)); sy = int'($signed(y));
    ux = int'(x); uy = int'(y);
    e = 0; cy = 0; ar = 1; r = 16'h0;
    case (o)
      4'd0:  begin e = sx + sy; cy = (ux + uy) > 65535; end
      4'd1:  begin e = sx + sy + int'(m_cf); cy = (ux + uy + int'(m_cf)) > 65535; end
      4'd2:  begin e = sx - sy; cy = ux >= uy; end
      4'd3:  begin e = sx - sy + int'(m_cf) - 1; cy = (ux - uy + int'(m_cf) - 1) >= 0; end
      4'd4:  begin e = sy - sx; cy = uy >= ux; end
      4'd5:  begin e = sy - sx + int'(m_cf) - 1; cy = (uy - ux + int'(m_cf) - 1) >= 0; end
      4'd11: begin e = (sx < 0) ? -sx : sx; cy = 0; end
      4'd12: begin e = sy + 1; cy = (y == 16'hFFFF); end
      4'd13: begin e = sy - 1; cy = (y != 16'h0); end
      4'd6:  begin ar = 0; r = x & y; end
      4'd7:  begin ar = 0; r = x | y; end
      4'd8:  begin ar = 0; r = x ^ y; end
      4'd9:  begin ar = 0; r = y; end
      4'd10: begin ar = 0; r = ~x; end
      default: ar = 0;
    endcase
    ov = ar && (e > 32767 || e < -32768);
    if (ar) r = (ov && s) ? ((e > 0) ? 16'h7FFF : 16'h8000) : e[15:0];
    ex = is && cd && (o < 4'd14);
    @(negedge clk);
    if (ex) begin
      if (d) m_fb = r; else m_res = r;
      m_zf = (r == 16'h0);
      m_nf = (o == 4'd11) ? x[15] : r[15];
      m_cf = cy;
      m_vf = ov | (l & m_vf & ~c);
    end else if (c) begin
      m_vf = 1'b0;
    end
    compare_all(rd, rz, rv);
    issue = 1'b0; clr = 1'b0;
  endtask

  task automatic model_reset();
    m_res = 16'h0; m_fb = 16'h0;
    m_zf = 0; m_nf = 0; m_vf = 0; m_cf = 0;
  endtask

  initial begin
    logic [15:0] vals [8];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'h5555; vals[6] = 16'hAAAA; vals[7] = 16'h8001;
    issue = 0; cond = 0; xs = 0; clr = 0; dst = 0; sat = 0; lat = 0;
    iinv = 0; ispec = 0; op = 0; iidx = 0; ys = 0; xe = 0; ye = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("R10", "R10", "R10");

    // R4: every immediate encoding, passed into the result register
    for (int sp = 0; sp < 2; sp++)
      for (int iv = 0; iv < 2; iv++)
        for (int ix = 0; ix < 16; ix++)
          run(4'd9, 0, 2'd3, 16'h0, 16'h0, 4'(ix), 1'(iv), 1'(sp),
              0, 0, 0, 0, 1, 1, "R4", "R6", "R7");

    // R1 R2 R6 R7 R8: all opcodes over corner operands, both saturation modes
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 14; o++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run(4'(o), 0, 2'd0, vals[i], vals[j], 4'd0, 0, 0, 1'(j[0]), 1'(s), 0, 0, 1, 1,
                (o >= 6 && o <= 10) ? "R2" : ((s == 1) ? "R8" : "R1"), "R6", "R7");

    // R3: forwarding of both registers and the zero source
    run(4'd9, 0, 2'd0, 16'h0, 16'h1234, 4'd0, 0, 0, 1, 0, 0, 0, 1, 1, "R3", "R6", "R7");
    run(4'd0, 0, 2'd1, 16'h0005, 16'h0, 4'd0, 0, 0, 0, 0, 0, 0, 1, 1, "R3", "R6", "R7");
    run(4'd2, 1, 2'd1, 16'h0, 16'h0, 4'd0, 0, 0, 1, 0, 0, 0, 1, 1, "R3", "R6", "R7");
    run(4'd0, 1, 2'd2, 16'h0, 16'h0, 4'd0, 0, 0, 1, 0, 0, 0, 1, 1, "R3", "R6", "R7");
    run(4'd1, 1, 2'd1, 16'h0, 16'h0, 4'd0, 0, 0, 0, 0, 0, 0, 1, 1, "R3", "R6", "R7");
    run(4'd4, 1, 2'd3, 16'h0, 16'h0, 4'd3, 1, 0, 0, 0, 0, 0, 1, 1, "R3", "R6", "R7");

    // R5: false condition, no issue, reserved opcodes
    run(4'd0, 0, 2'd0, 16'h7FFF, 16'h0001, 4'd0, 0, 0, 0, 0, 0, 0, 1, 0, "R5", "R5", "R5");
    run(4'd10, 0, 2'd0, 16'h1111, 16'h0, 4'd0, 0, 0, 1, 0, 0, 0, 0, 1, "R5", "R5", "R5");
    run(4'd14, 0, 2'd0, 16'h0003, 16'h0004, 4'd0, 0, 0, 0, 0, 0, 0, 1, 1, "R5", "R5", "R5");
    run(4'd15, 0, 2'd0, 16'h0003, 16'h0004, 4'd0, 0, 0, 1, 0, 0, 0, 1, 1, "R5", "R5", "R5");

    // R9: sticky overflow and its clear
    run(4'd0, 0, 2'd0, 16'h7FFF, 16'h0001, 4'd0, 0, 0, 0, 0, 1, 0, 1, 1, "R9", "R6", "R9");
    run(4'd0, 0, 2'd0, 16'h0001, 16'h0001, 4'd0, 0, 0, 0, 0, 1, 0, 1, 1, "R9", "R6", "R9");
    run(4'd6, 0, 2'd0, 16'h00FF, 16'h0F0F, 4'd0, 0, 0, 1, 0, 1, 0, 1, 1, "R9", "R6", "R9");
    run(4'd0, 0, 2'd0, 16'h0002, 16'h0001, 4'd0, 0, 0, 0, 0, 1, 1, 1, 1, "R9", "R6", "R9");
    run(4'd2, 0, 2'd0, 16'h8000, 16'h0001, 4'd0, 0, 0, 0, 0, 1, 0, 1, 1, "R9", "R6", "R9");
    run(4'd0, 0, 2'd0, 16'h0, 16'h0, 4'd0, 0, 0, 0, 0, 1, 1, 0, 1, "R9", "R6", "R9");
    run(4'd2, 0, 2'd0, 16'h8000, 16'h0001, 4'd0, 0, 0, 0, 0, 1, 0, 1, 1, "R9", "R6", "R9");
    run(4'd0, 0, 2'd0, 16'h0001, 16'h0001, 4'd0, 0, 0, 0, 0, 0, 0, 1, 1, "R9", "R6", "R9");

    // R10: reset in the middle of a run
    run(4'd10, 0, 2'd0, 16'h0000, 16'h0, 4'd0, 0, 0, 1, 0, 0, 0, 1, 1, "R10", "R6", "R7");
    rst_n = 0;
    model_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("R10", "R10", "R10");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule